// File: doc/BRIEF.md
# Suspend Modulation Duty Generator

This block throttles a processor by toggling an active-low suspend request. The sequence alternates between two phases. In the run phase the request is released and the processor executes. In the suspend phase the request is driven low and the processor idles. The two phase lengths are programmable in units of one time-base tick, nominally 32 µs. A prescaler derives that tick from the system clock. The resulting throughput fraction is run/(run+suspend).

Software programs the block through a byte-wide register file on a simple write-enable/address/data bus, and every register reads back what was written. Two speedup timers respond to activity pulses, one for interrupts and one for video. When its speedup enable bit is set, a pulse reloads that timer with a programmed count of millisecond ticks. While either timer is nonzero, throttling pauses and the processor runs at full speed.

Top module: `susp_mod_top`

## Requirements
- R1: After reset every register reads 0 and `susp_n` is 1.
- R2: The registers sit at these addresses: 0 run count, 1 suspend count, 2 configuration (bit 0 is modulation enable), 3 power-management enable (bit 3 is interrupt speedup, bit 4 is video speedup), 4 interrupt speedup reload, 5 video speedup reload. Each reads back the last value written. `bus_rdata` is valid one cycle after `bus_addr` is presented. Unmapped addresses read 0.
- R3: While the enable bit is 0, `susp_n` stays 1. Clearing the enable bit releases `susp_n` within two cycles.
- R4: In steady modulation, each high interval of `susp_n` lasts exactly run count × TICK_DIV clock cycles.
- R5: In steady modulation, each low interval of `susp_n` lasts exactly suspend count × TICK_DIV clock cycles.
- R6: After enable, the sequence starts with the run phase, so `susp_n` stays high for roughly one run period before its first fall.
- R7: A phase whose count is 0 is skipped. A zero suspend count keeps `susp_n` at 1, a zero run count keeps it at 0, and two zero counts keep it at 1.
- R8: A new count takes effect only at the next phase boundary. A phase already running keeps its length.
- R9: An activity pulse whose speedup bit is set loads that timer with its reload value in millisecond ticks. While either timer is nonzero, `susp_n` is held at 1 and the phase counter pauses.
- R10: An activity pulse whose speedup bit is clear has no effect on `susp_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_pulse | input | 1 | Interrupt activity pulse |
| vid_pulse | input | 1 | Video activity pulse |
| susp_n | output | 1 | Active-low suspend request, registered |

## Verification
The bench measures the exact lengths of the high and low intervals of `susp_n`. A counter that is off by one on reload or on the boundary would show up as an interval one tick too long or too short. It rewrites the suspend count in the middle of a suspend phase. A design that reloads the counter at once would cut that phase short or stretch it, instead of applying the new length to the next phase. It covers zero counts in every combination, which catches a counter that wraps from 0 to 255. It also sends activity pulses with the speedup bit set and with it clear. A design that ignores the enable bit would then throttle during the hold window or pause when it should not.

// File: rtl/susp_mod_pkg.sv
package susp_mod_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_SUSP} phase_t;

  localparam int ADR_RUN    = 0;
  localparam int ADR_SUSP   = 1;
  localparam int ADR_CFG    = 2;
  localparam int ADR_PMEN   = 3;
  localparam int ADR_IRQ_RL = 4;
  localparam int ADR_VID_RL = 5;

  localparam int CFG_EN_BIT  = 0;
  localparam int PM_IRQ_BIT  = 3;
  localparam int PM_VID_BIT  = 4;
  localparam int NUM_SPEEDUP = 2;
endpackage

// File: rtl/susp_mod_regs.sv
module susp_mod_regs #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] run_cnt,
  output logic [DATA_W-1:0] susp_cnt,
  output logic [DATA_W-1:0] cfg,
  output logic [DATA_W-1:0] pmen,
  output logic [DATA_W-1:0] irq_rl,
  output logic [DATA_W-1:0] vid_rl
);
  import susp_mod_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt  <= '0;
      susp_cnt <= '0;
      cfg      <= '0;
      pmen     <= '0;
      irq_rl   <= '0;
      vid_rl   <= '0;
    end else if (we) begin
      case (int'(addr))
        ADR_RUN:    run_cnt  <= wdata;
        ADR_SUSP:   susp_cnt <= wdata;
        ADR_CFG:    cfg      <= wdata;
        ADR_PMEN:   pmen     <= wdata;
        ADR_IRQ_RL: irq_rl   <= wdata;
        ADR_VID_RL: vid_rl   <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (int'(addr))
        ADR_RUN:    rdata <= run_cnt;
        ADR_SUSP:   rdata <= susp_cnt;
        ADR_CFG:    rdata <= cfg;
        ADR_PMEN:   rdata <= pmen;
        ADR_IRQ_RL: rdata <= irq_rl;
        ADR_VID_RL: rdata <= vid_rl;
        default:    rdata <= '0;
      endcase
    end
  end

  // R2: a write to the suspend count shows up in the held value
  a_r2_susp_write: assert property (@(posedge clk) disable iff (rst)
    (we && int'(addr) == ADR_SUSP) |=> (susp_cnt == $past(wdata)));
endmodule

// File: rtl/susp_mod_prescale.sv
module susp_mod_prescale #(
  parameter int TICK_DIV = 1600,
  parameter int MS_DIV   = 31
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic ms_tick
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int MW = (MS_DIV > 1) ? $clog2(MS_DIV) : 1;

  logic [TW-1:0] div_q;
  logic [MW-1:0] ms_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      ms_q    <= '0;
      tick    <= 1'b0;
      ms_tick <= 1'b0;
    end else begin
      tick    <= 1'b0;
      ms_tick <= 1'b0;
      if (int'(div_q) == TICK_DIV - 1) begin
        div_q <= '0;
        tick  <= 1'b1;
        if (int'(ms_q) == MS_DIV - 1) begin
          ms_q    <= '0;
          ms_tick <= 1'b1;
        end else begin
          ms_q <= ms_q + 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  generate
    if (TICK_DIV > 1) begin : g_spacing
      // R4: ticks are never back to back when the divider exceeds one
      a_r4_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate

  // R9: a millisecond tick only coincides with a base tick
  a_r9_ms_on_tick: assert property (@(posedge clk) disable iff (rst)
    ms_tick |-> tick);
endmodule

// File: rtl/susp_mod_speedup.sv
module susp_mod_speedup #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act,
  input  logic             act_en,
  input  logic             ms_tick,
  input  logic [CNT_W-1:0] reload,
  output logic             hold
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (act && act_en) cnt_q <= reload;
    else if (ms_tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign hold = (cnt_q != '0);

  // R9: qualified activity loads the reload value
  a_r9_reload: assert property (@(posedge clk) disable iff (rst)
    (act && act_en) |=> (cnt_q == $past(reload)));
  // R10: unqualified activity never raises the count
  a_r10_no_load: assert property (@(posedge clk) disable iff (rst)
    !(act && act_en) |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/susp_mod_seq.sv
module susp_mod_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             hold,
  input  logic             tick,
  input  logic [CNT_W-1:0] run_cnt,
  input  logic [CNT_W-1:0] susp_cnt,
  output logic             susp_n
);
  import susp_mod_pkg::*;

  phase_t           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_nz, susp_nz;

  assign run_nz  = (run_cnt != '0);
  assign susp_nz = (susp_cnt != '0);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (!en) begin
      ph_d  = PH_IDLE;
      cnt_d = '0;
    end else if (!hold) begin
      case (ph_q)
        PH_IDLE: begin
          if (run_nz)       begin ph_d = PH_RUN;  cnt_d = run_cnt;  end
          else if (susp_nz) begin ph_d = PH_SUSP; cnt_d = susp_cnt; end
        end
        PH_RUN: if (tick) begin
          if (cnt_q == 1) begin
            if (susp_nz)     begin ph_d = PH_SUSP; cnt_d = susp_cnt; end
            else if (run_nz) begin ph_d = PH_RUN;  cnt_d = run_cnt;  end
            else             begin ph_d = PH_IDLE; cnt_d = '0;       end
          end else cnt_d = cnt_q - 1'b1;
        end
        PH_SUSP: if (tick) begin
          if (cnt_q == 1) begin
            if (run_nz)       begin ph_d = PH_RUN;  cnt_d = run_cnt;  end
            else if (susp_nz) begin ph_d = PH_SUSP; cnt_d = susp_cnt; end
            else              begin ph_d = PH_IDLE; cnt_d = '0;       end
          end else cnt_d = cnt_q - 1'b1;
        end
        default: begin ph_d = PH_IDLE; cnt_d = '0; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      susp_n <= 1'b1;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      susp_n <= !(en && !hold && ph_d == PH_SUSP);
    end
  end

  // R3: disabled modulation releases the request
  a_r3_disabled_high: assert property (@(posedge clk) disable iff (rst)
    !en |=> susp_n);
  // R9: speedup hold releases the request
  a_r9_hold_high: assert property (@(posedge clk) disable iff (rst)
    hold |=> susp_n);
  // R7: an active phase never carries a zero count
  a_r7_no_zero_phase: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_IDLE) |-> (cnt_q != '0));
  // R9: the counter is frozen while held
  a_r9_pause: assert property (@(posedge clk) disable iff (rst)
    (en && hold) |=> $stable(cnt_q));
endmodule

// File: rtl/susp_mod_top.sv
module susp_mod_top #(
  parameter int ADDR_W   = 3,
  parameter int CNT_W    = 8,
  parameter int TICK_DIV = 1600,
  parameter int MS_DIV   = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              irq_pulse,
  input  logic              vid_pulse,
  output logic              susp_n
);
  import susp_mod_pkg::*;

  logic [CNT_W-1:0] run_cnt, susp_cnt, cfg, pmen, irq_rl, vid_rl;
  logic             tick, ms_tick;
  logic [NUM_SPEEDUP-1:0] act, act_en, hold;
  logic [CNT_W-1:0] rl [NUM_SPEEDUP];

  susp_mod_regs #(.ADDR_W(ADDR_W), .DATA_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .run_cnt(run_cnt), .susp_cnt(susp_cnt), .cfg(cfg),
    .pmen(pmen), .irq_rl(irq_rl), .vid_rl(vid_rl));

  susp_mod_prescale #(.TICK_DIV(TICK_DIV), .MS_DIV(MS_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick(tick), .ms_tick(ms_tick));

  assign act    = {vid_pulse, irq_pulse};
  assign act_en = {pmen[PM_VID_BIT], pmen[PM_IRQ_BIT]};
  assign rl[0]  = irq_rl;
  assign rl[1]  = vid_rl;

  generate
    for (genvar i = 0; i < NUM_SPEEDUP; i++) begin : g_spd
      susp_mod_speedup #(.CNT_W(CNT_W)) u_spd (
        .clk(clk), .rst(rst), .act(act[i]), .act_en(act_en[i]),
        .ms_tick(ms_tick), .reload(rl[i]), .hold(hold[i]));
    end
  endgenerate

  susp_mod_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .en(cfg[CFG_EN_BIT]), .hold(|hold), .tick(tick),
    .run_cnt(run_cnt), .susp_cnt(susp_cnt), .susp_n(susp_n));
endmodule

// File: tb/susp_mod_top_test.sv
module susp_mod_top_test;
  localparam int TD = 4;
  localparam int MD = 3;
  localparam int MS = TD * MD;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_pulse = 1'b0, vid_pulse = 1'b0;
  logic       susp_n;
  int         n_chk = 0, n_bad = 0, cyc = 0;
  bit         done = 1'b0;

  susp_mod_top #(.ADDR_W(3), .CNT_W(8), .TICK_DIV(TD), .MS_DIV(MD)) uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pulse(irq_pulse),
    .vid_pulse(vid_pulse), .susp_n(susp_n));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    bus_addr = 3'(a);
    @(negedge clk);
    d = int'(bus_rdata);
  endtask

  // waits until susp_n equals v; returns cycles waited (-1 on timeout)
  task automatic wait_lvl(logic v, int lim, output int n);
    n = 0;
    while (susp_n !== v) begin
      @(negedge clk); n++;
      if (n > lim) begin n = -1; return; end
    end
  endtask

  // length of the run of level v starting now
  task automatic run_len(logic v, output int n);
    n = 0;
    while (susp_n === v && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic count_lvl(logic v, int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (susp_n === v) n++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    int d;
    do_reset();
    chk("R1 susp_n", int'(susp_n), 1);
    for (int a = 0; a < 6; a++) begin
      rd(a, d); chk("R1 reg reset", d, 0);
    end
  endtask

  task automatic t_readback();
    int d;
    for (int a = 0; a < 6; a++) wr(a, 8'h5A ^ (a * 17));
    for (int a = 0; a < 6; a++) begin
      rd(a, d); chk("R2 readback", d, 8'h5A ^ (a * 17));
    end
    wr(6, 8'hFF); rd(6, d); chk("R2 unmapped", d, 0);
    rd(7, d); chk("R2 unmapped", d, 0);
    do_reset();
  endtask

  task automatic t_disabled();
    int n;
    wr(0, 2); wr(1, 3); wr(2, 8'hFE);
    count_lvl(1'b1, 60, n); chk("R3 disabled high", n, 60);
  endtask

  task automatic t_steady();
    int n, hi, lo;
    do_reset();
    wr(0, 3); wr(1, 2); wr(2, 1);
    wait_lvl(1'b0, 40, n);
    chk("R6 first fall delay in range", int'(n >= 2*TD-4 && n <= 3*TD+3), 1);
    run_len(1'b0, lo); chk("R5 low length", lo, 2*TD);
    run_len(1'b1, hi); chk("R4 high length", hi, 3*TD);
    run_len(1'b0, lo); chk("R5 low length 2", lo, 2*TD);
    run_len(1'b1, hi); chk("R4 high length 2", hi, 3*TD);
  endtask

  task automatic t_boundary();
    int n, lo;
    wait_lvl(1'b0, 60, n);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'd1; bus_wdata = 8'd6;
    @(negedge clk); bus_we = 1'b0;
    run_len(1'b0, lo); chk("R8 running phase kept", lo + 2, 2*TD);
    run_len(1'b1, n);
    run_len(1'b0, lo); chk("R8 new length next phase", lo, 6*TD);
    wr(2, 0);
    count_lvl(1'b1, 30, n); chk("R3 disable releases", n, 30);
  endtask

  task automatic t_zero();
    int n;
    do_reset();
    wr(0, 2); wr(1, 0); wr(2, 1);
    count_lvl(1'b1, 50, n); chk("R7 zero suspend count", n, 50);
    wr(2, 0); wr(0, 0); wr(1, 2); wr(2, 1);
    repeat (3) @(negedge clk);
    count_lvl(1'b0, 50, n); chk("R7 zero run count", n, 50);
    wr(1, 0);
    repeat (3*TD) @(negedge clk);
    count_lvl(1'b1, 40, n); chk("R7 both zero", n, 40);
  endtask

  task automatic t_speedup(bit vid, bit en_bit, int rl);
    int n;
    do_reset();
    wr(0, 1); wr(1, 6);
    wr(3, en_bit ? (vid ? 8'h10 : 8'h08) : (vid ? 8'h08 : 8'h10));
    wr(vid ? 5 : 4, rl);
    wr(2, 1);
    repeat (5*TD) @(negedge clk);
    @(negedge clk);
    if (vid) vid_pulse = 1'b1; else irq_pulse = 1'b1;
    @(negedge clk);
    vid_pulse = 1'b0; irq_pulse = 1'b0;
    @(negedge clk);
    if (en_bit) begin
      count_lvl(1'b1, (rl-1)*MS - 2, n);
      chk(vid ? "R9 video hold" : "R9 irq hold", n, (rl-1)*MS - 2);
      wait_lvl(1'b0, MS + 8*TD, n);
      chk("R9 resumes after hold", int'(n >= 0), 1);
    end else begin
      count_lvl(1'b0, 2*TD + 2, n);
      chk("R10 unqualified pulse ignored", int'(n > 0), 1);
    end
  endtask

  initial begin
    t_reset();
    t_readback();
    t_disabled();
    t_steady();
    t_boundary();
    t_zero();
    t_speedup(1'b0, 1'b1, 4);
    t_speedup(1'b1, 1'b1, 5);
    t_speedup(1'b0, 1'b0, 6);
    t_speedup(1'b1, 1'b0, 6);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule